// File: doc/BRIEF.md
# Programmable Burst Column Address Sequencer

This block generates the column address for each beat of a memory read or write burst. A mode word, loaded through a 12-bit op-code, selects the burst length, the beat ordering and the write behaviour. It also carries a read-latency code that the block decodes and exports as a value. A start strobe registers a starting column and the access direction. From the next cycle on, the block presents one column per clock together with a beat-valid flag and a last-beat flag. A terminate strobe ends a burst at once, and a new start abandons any running burst.

Bursts of 2, 4 and 8 beats stay inside an aligned block of that size. The low column bits either count up modulo the length or are the start bits XOR the beat index. A full-page burst walks the whole row, wraps from the top column to column 0 and runs until it is stopped. The memory array, the data path and command decoding sit outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: After synchronous reset, beat_valid and beat_last are 0, mode_err is 0, and the mode is length 1, sequential, latency 2, writes following the programmed length (read_latency reads 2).
- R2: Mode op-code bits [2:0] select the length: 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8. The first beat appears the cycle after start, and beat_last is high on exactly the final beat. beat_valid drops the cycle after the last beat unless a new start arrives.
- R3: With op-code bit 3 = 0 (sequential), the low log2(length) column bits count up from the start bits modulo the length, and the upper bits stay those of the start column.
- R4: With op-code bit 3 = 1 (interleaved), each beat's low bits equal the start's low bits XOR the beat index, and the upper bits stay fixed.
- R5: With length 1, the burst is the start column alone, whatever bit 3 holds.
- R6: Length code 111 (full page, sequential only) steps through every column, wraps from the top column to 0, never raises beat_last, and runs until terminated or restarted.
- R7: Op-code bits [6:4] give the latency: 010 exports read_latency = 2 and 011 exports 3.
- R8: With op-code bit 9 = 1, a write start (start_write = 1) gives a single beat. With bit 9 = 0, writes use the programmed length, except that a full-page length gives a single-beat write. Reads always use the programmed length.
- R9: A start is accepted on any cycle, including during a burst, and restarts from the new column at beat 0. Start wins over a terminate in the same cycle.
- R10: A terminate without start clears beat_valid on the next cycle.
- R11: A load with a reserved length code (100, 101, 110), full page with bit 3 = 1, or a latency code other than 010/011 sets mode_err and keeps the previous mode. A legal load clears mode_err.
- R12: A burst uses the mode held when its start was sampled. A load during the burst, or in the same cycle as the start, does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Load strobe for the mode op-code |
| mode_op | input | 12 | Mode op-code |
| start | input | 1 | Burst start strobe |
| start_col | input | COL_W | Starting column |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| term | input | 1 | Terminate strobe |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | The current beat is the final one |
| mode_err | output | 1 | Last load was rejected as reserved |
| read_latency | output | 2 | Decoded read latency in cycles |

## Verification
The bench builds the block with the default COL_W = 8, so a full page is 256 columns. Starting near the top of the row brings the 255-to-0 wrap within a handful of cycles. Under this setting all eight starting offsets of an 8-beat block, in both orderings, fit in a short run. The reference model in the bench predicts every cycle's outputs. This covers restarts mid-burst, start and terminate in the same cycle, and loads that coincide with a start or arrive during a burst.

// File: rtl/burst_seq_pkg.sv
// Package: shared encodings for the burst column sequencer.
// Assumes a 12-bit mode op-code with the field positions below.
package burst_seq_pkg;

    localparam int OP_W = 12;

    // Field positions inside the mode op-code
    localparam int LEN_LSB  = 0;
    localparam int ITL_BIT  = 3;
    localparam int LAT_LSB  = 4;
    localparam int WR1_BIT  = 9;

    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    localparam logic [2:0] LAT_CODE_2 = 3'b010;
    localparam logic [2:0] LAT_CODE_3 = 3'b011;

    typedef struct packed {
        logic       wr_single;
        logic [2:0] lat_code;
        logic       itl;
        logic [2:0] len_code;
    } mode_t;

    localparam mode_t MODE_RESET = '{wr_single: 1'b0, lat_code: LAT_CODE_2,
                                     itl: 1'b0, len_code: LEN_1};

    // Extract the used fields from an op-code
    function automatic mode_t op_to_mode(input logic [OP_W-1:0] op);
        mode_t m;
        m.wr_single = op[WR1_BIT];
        m.lat_code  = op[LAT_LSB +: 3];
        m.itl       = op[ITL_BIT];
        m.len_code  = op[LEN_LSB +: 3];
        return m;
    endfunction

    // True when the mode carries any reserved combination
    function automatic logic mode_reserved(input mode_t m);
        logic bad_len;
        logic bad_lat;
        bad_len = (m.len_code[2] && (m.len_code != LEN_PAGE)) ||
                  ((m.len_code == LEN_PAGE) && m.itl);
        bad_lat = (m.lat_code != LAT_CODE_2) && (m.lat_code != LAT_CODE_3);
        return bad_len || bad_lat;
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
// Mode register: validates and holds the burst mode word.
// Assumes a load with any reserved field is rejected as a whole.
module burst_mode_reg
    import burst_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] op,
    output mode_t           mode,
    output logic            err
);

    mode_t cand;
    logic  unused_op_bits;

    // Decode the candidate mode from the op-code
    always_comb begin
        cand = op_to_mode(op);
    end

    assign unused_op_bits = ^{op[11:10], op[8:7]};

    // Hold the mode; keep old contents on a reserved load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
            err  <= 1'b0;
        end else if (load) begin
            if (mode_reserved(cand)) begin
                err <= 1'b1;
            end else begin
                mode <= cand;
                err  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat controller: captures a burst at start and steps its beat index.
// Assumes start has priority over terminate in the same cycle.
module burst_beat_ctrl
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             term,
    input  logic [2:0]       len_code,
    input  logic             itl_mode,
    input  logic             wr_single,
    output logic             active,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] mask,
    output logic             itl,
    output logic             last
);

    localparam logic [COL_W-1:0] ALL_ONES = '1;

    logic             full;
    logic             is_page;
    logic             wr_one;
    logic [COL_W-1:0] len_mask;

    // Translate the length code into a low-bit block mask
    always_comb begin
        case (len_code)
            LEN_2:    len_mask = COL_W'(1);
            LEN_4:    len_mask = COL_W'(3);
            LEN_8:    len_mask = COL_W'(7);
            LEN_PAGE: len_mask = ALL_ONES;
            default:  len_mask = '0;
        endcase
    end

    // Decide whether a write start collapses to one beat
    always_comb begin
        is_page = (len_code == LEN_PAGE);
        wr_one  = start_write && (wr_single || is_page);
    end

    // Final beat of a bounded burst
    assign last = active && !full && (idx == mask);

    // Burst state: capture on start, stop on terminate or last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            base   <= '0;
            mask   <= '0;
            itl    <= 1'b0;
            full   <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            base   <= start_col;
            mask   <= wr_one ? '0 : len_mask;
            itl    <= itl_mode;
            full   <= is_page && !wr_one;
        end else if (term) begin
            active <= 1'b0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/burst_col_calc.sv
// Column calculator: forms the beat column from base, index and mask.
// Assumes the mask is a contiguous run of low ones.
module burst_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             itl,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_sum;

    // Sequential candidate: carries past the block are dropped per bit
    assign seq_sum = base + idx;

    // Per bit: fixed outside the block, ordered inside it
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask[b]) begin
                col[b] = base[b];
            end else if (itl) begin
                col[b] = base[b] ^ idx[b];
            end else begin
                col[b] = seq_sum[b];
            end
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
// Top: programmable burst column address sequencer.
// Assumes one beat per clock; outputs follow the registered burst state.
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [11:0]      mode_op,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_write,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             mode_err,
    output logic [1:0]       read_latency
);

    mode_t            mode;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] mask;
    logic             itl;
    logic             active;
    logic             last;

    burst_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .op    (mode_op),
        .mode  (mode),
        .err   (mode_err)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) u_beat (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_col   (start_col),
        .start_write (start_write),
        .term        (term),
        .len_code    (mode.len_code),
        .itl_mode    (mode.itl),
        .wr_single   (mode.wr_single),
        .active      (active),
        .idx         (idx),
        .base        (base),
        .mask        (mask),
        .itl         (itl),
        .last        (last)
    );

    burst_col_calc #(.COL_W(COL_W)) u_calc (
        .base (base),
        .idx  (idx),
        .mask (mask),
        .itl  (itl),
        .col  (col_addr)
    );

    // Export the decoded latency in cycles
    always_comb begin
        read_latency = (mode.lat_code == LAT_CODE_3) ? 2'd3 : 2'd2;
    end

    assign beat_valid = active;
    assign beat_last  = last;

endmodule

// File: rtl/burst_col_seq_chk.sv
// Checker: temporal properties of the sequencer seen at its ports.
// Assumes it is bound to every instance of burst_col_seq.
module burst_col_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic [11:0]      mode_op,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             term,
    input logic [COL_W-1:0] col_addr,
    input logic             beat_valid,
    input logic             beat_last,
    input logic             mode_err,
    input logic [1:0]       read_latency
);

    logic unused_chk_bits;
    assign unused_chk_bits = ^{mode_op[11:7], mode_op[3:0]};

    // R9
    start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && col_addr == $past(start_col)));

    // R10
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !beat_valid);

    // R2
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last && !start) |=> !beat_valid);

    // R6
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !term) |=> beat_valid);

    // R7
    lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (read_latency == 2'd2 || read_latency == 2'd3));

    // R11
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && mode_op[6:4] != 3'b010 && mode_op[6:4] != 3'b011) |=> mode_err);

    // R12
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> ($stable(read_latency) && $stable(mode_err)));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_load    (mode_load),
    .mode_op      (mode_op),
    .start        (start),
    .start_col    (start_col),
    .term         (term),
    .col_addr     (col_addr),
    .beat_valid   (beat_valid),
    .beat_last    (beat_last),
    .mode_err     (mode_err),
    .read_latency (read_latency)
);

// File: tb/burst_col_seq_tb.sv
// Scoreboard bench: the driver pushes one expected item per cycle,
// the monitor pops and compares it just after the clock edge.
module burst_col_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_load = 1'b0;
    logic [11:0]      mode_op = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             start_write = 1'b0;
    logic             term = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             beat_valid;
    logic             beat_last;
    logic             mode_err;
    logic [1:0]       read_latency;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         valid;
        bit [7:0]   col;
        bit         last;
        bit         err;
        bit [1:0]   lat;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference model state
    bit [2:0] m_len  = 3'b000;
    bit       m_itl  = 1'b0;
    bit [2:0] m_lat  = 3'b010;
    bit       m_wr1  = 1'b0;
    bit       m_err  = 1'b0;
    bit       b_act  = 1'b0;
    bit [7:0] b_idx  = '0;
    bit [7:0] b_base = '0;
    bit [7:0] b_mask = '0;
    bit       b_itl  = 1'b0;
    bit       b_full = 1'b0;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_load    (mode_load),
        .mode_op      (mode_op),
        .start        (start),
        .start_col    (start_col),
        .start_write  (start_write),
        .term         (term),
        .col_addr     (col_addr),
        .beat_valid   (beat_valid),
        .beat_last    (beat_last),
        .mode_err     (mode_err),
        .read_latency (read_latency)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit [11:0] mk_op(bit [2:0] len, bit itl, bit [2:0] lat, bit wr1);
        return {2'b00, wr1, 2'b00, lat, itl, len};
    endfunction

    function automatic bit [7:0] len_to_mask(bit [2:0] len);
        case (len)
            3'b001:  return 8'h01;
            3'b010:  return 8'h03;
            3'b011:  return 8'h07;
            3'b111:  return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit model_last();
        return b_act && !b_full && (b_idx == b_mask);
    endfunction

    function automatic bit [7:0] model_col();
        bit [7:0] low;
        if (b_itl) return b_base ^ b_idx;
        low = (b_base + b_idx) & b_mask;
        return (b_base & ~b_mask) | low;
    endfunction

    // One driven cycle: apply inputs, advance the model, queue the outcome
    task automatic cyc(bit ld, bit [11:0] op, bit st, bit [7:0] col, bit wr, bit tm, string tag);
        exp_t e;
        bit   bad;
        bit   wr_one;
        @(negedge clk);
        mode_load = ld; mode_op = op; start = st; start_col = col;
        start_write = wr; term = tm;
        if (st) begin
            wr_one = wr && (m_wr1 || m_len == 3'b111);
            b_act = 1'b1; b_idx = '0; b_base = col;
            b_mask = wr_one ? 8'h00 : len_to_mask(m_len);
            b_itl = m_itl;
            b_full = (m_len == 3'b111) && !wr_one;
        end else if (tm) begin
            b_act = 1'b0;
        end else if (b_act) begin
            if (model_last()) b_act = 1'b0;
            else b_idx = b_idx + 8'd1;
        end
        if (ld) begin
            bad = (op[2] && op[2:0] != 3'b111) || (op[2:0] == 3'b111 && op[3]) ||
                  (op[6:4] != 3'b010 && op[6:4] != 3'b011);
            if (bad) m_err = 1'b1;
            else begin
                m_err = 1'b0; m_len = op[2:0]; m_itl = op[3];
                m_lat = op[6:4]; m_wr1 = op[9];
            end
        end
        e.valid = b_act; e.col = model_col(); e.last = model_last();
        e.err = m_err; e.lat = (m_lat == 3'b011) ? 2'd3 : 2'd2; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(string tag);
        cyc(1'b0, 12'h000, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic load(bit [11:0] op, string tag);
        cyc(1'b1, op, 1'b0, 8'h00, 1'b0, 1'b0, tag);
    endtask

    // Start a burst and let it run for the given number of further cycles
    task automatic burst(bit [7:0] col, bit wr, int run, string tag);
        cyc(1'b0, 12'h000, 1'b1, col, wr, 1'b0, tag);
        for (int i = 0; i < run; i++) idle(tag);
    endtask

    // Monitor: compare the queued expectation just after each edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_checks++;
            if (beat_valid !== e.valid || beat_last !== e.last || mode_err !== e.err ||
                read_latency !== e.lat || (e.valid && col_addr !== e.col)) begin
                n_errors++;
                $display("FAIL %s: valid=%0b col=%02h last=%0b err=%0b lat=%0d expected valid=%0b col=%02h last=%0b err=%0b lat=%0d",
                         e.tag, beat_valid, col_addr, beat_last, mode_err, read_latency,
                         e.valid, e.col, e.last, e.err, e.lat);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle("R1"); idle("R1");

        // R7 latency 3, R3 sequential length 4 wrapping in its block
        load(mk_op(3'b010, 1'b0, 3'b011, 1'b0), "R7");
        burst(8'h35, 1'b0, 5, "R3");
        // R3 sequential length 8
        load(mk_op(3'b011, 1'b0, 3'b010, 1'b0), "R7");
        burst(8'h7D, 1'b0, 9, "R3");
        // R4 interleaved length 4 and 8
        load(mk_op(3'b010, 1'b1, 3'b010, 1'b0), "R4");
        burst(8'h11, 1'b0, 5, "R4");
        load(mk_op(3'b011, 1'b1, 3'b011, 1'b0), "R4");
        burst(8'h25, 1'b0, 9, "R4");
        burst(8'hEE, 1'b0, 9, "R4");
        // R2 length 2 at top of row, back-to-back bursts
        load(mk_op(3'b001, 1'b0, 3'b010, 1'b0), "R2");
        burst(8'hFF, 1'b0, 1, "R2");
        burst(8'h40, 1'b0, 3, "R2");
        // R5 length 1 ignores interleave bit
        load(mk_op(3'b000, 1'b1, 3'b010, 1'b0), "R5");
        burst(8'h9A, 1'b0, 2, "R5");
        // R6 full page wraps 255 to 0, then R10 terminate
        load(mk_op(3'b111, 1'b0, 3'b010, 1'b0), "R6");
        burst(8'hFC, 1'b0, 7, "R6");
        cyc(1'b0, 12'h000, 1'b0, 8'h00, 1'b0, 1'b1, "R10");
        idle("R10");
        // R8 full-page write with bit 9 clear is a single beat
        burst(8'h10, 1'b1, 3, "R8");
        // R9 restart mid-burst, and start beats terminate
        load(mk_op(3'b011, 1'b0, 3'b010, 1'b0), "R9");
        burst(8'h02, 1'b0, 2, "R9");
        burst(8'hA6, 1'b0, 2, "R9");
        cyc(1'b0, 12'h000, 1'b1, 8'h31, 1'b0, 1'b1, "R9");
        idle("R9"); idle("R9");
        cyc(1'b0, 12'h000, 1'b0, 8'h00, 1'b0, 1'b1, "R10");
        idle("R10");
        // R8 writes: programmed length with bit 9 clear, single with bit 9 set
        load(mk_op(3'b010, 1'b0, 3'b010, 1'b0), "R8");
        burst(8'h0E, 1'b1, 5, "R8");
        load(mk_op(3'b011, 1'b0, 3'b010, 1'b1), "R8");
        burst(8'h0E, 1'b1, 3, "R8");
        burst(8'h0E, 1'b0, 9, "R8");
        // R11 reserved loads keep previous mode
        load(mk_op(3'b100, 1'b0, 3'b011, 1'b0), "R11");
        burst(8'h50, 1'b0, 9, "R11");
        load(mk_op(3'b111, 1'b1, 3'b010, 1'b0), "R11");
        load(mk_op(3'b001, 1'b0, 3'b001, 1'b0), "R11");
        load(mk_op(3'b110, 1'b0, 3'b010, 1'b0), "R11");
        load(mk_op(3'b010, 1'b1, 3'b011, 1'b0), "R11");
        idle("R11");
        // R12 load during a burst and in the start cycle
        burst(8'h83, 1'b0, 1, "R12");
        load(mk_op(3'b011, 1'b0, 3'b010, 1'b0), "R12");
        idle("R12"); idle("R12"); idle("R12");
        cyc(1'b1, mk_op(3'b001, 1'b1, 3'b010, 1'b0), 1'b1, 8'hC4, 1'b0, 1'b0, "R12");
        for (int i = 0; i < 9; i++) idle("R12");
        burst(8'hC4, 1'b0, 3, "R12");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule